// File: doc/BRIEF.md
# Command Queue Ring Controller

This block is the front end of the command queue of an interrupt translation service. Software places 32-byte commands in a ring in memory. It programs the ring's physical base and its length in 4 KiB pages through a 64-bit base register. It then moves a write offset forward to announce new commands. The block compares the write offset with its own read offset. While they differ, it fetches one command at a time from memory and hands it to a downstream consumer on a valid/ready port. After that it moves the read offset forward, wrapping at the end of the ring.

Software reaches four registers through a small access port: control, base, write offset and read offset. A write is either a full 64-bit word or one 32-bit half. A read returns the addressed half in the low 32 bits of the read data. The control register reports a quiescent flag that is set when the ring is drained. Decoding and executing the commands happens elsewhere.

Top module: `cq_ring_ctrl`

## Requirements
- R1: After reset the enable bit, the base register, the write offset and the read offset are all 0. No memory request and no command are presented.
- R2: Register select codes are 0 for control, 1 for base, 2 for write offset and 3 for read offset. With `reg_wide`=1 the access covers all 64 bits. With `reg_wide`=0, `reg_hi` picks bits 63:32 (1) or bits 31:0 (0). A half write leaves the other half unchanged. A half read returns that half in bits 31:0, with bits 63:32 zero.
- R3: Both offsets hold only bits 19:5. All other bits read as 0 and are dropped on write.
- R4: A write to the base register while the enable bit is 1 changes nothing.
- R5: A base write accepted while the enable bit is 0 sets both offsets to 0.
- R6: A write offset value larger than the ring length, (base bits 7:0 + 1) × 4096 bytes, is discarded and the old value stays.
- R7: Each command is fetched with a single memory request at address {base bits 51:12, 12'b0} + read offset. At most one request or command is in flight at a time. The returned 256-bit data is presented unchanged on the command port.
- R8: A presented command stays valid and stable until it is accepted. Only then does the read offset advance by 32.
- R9: When the read offset plus 32 reaches the ring length, the read offset wraps to 0.
- R10: A fetch whose response carries the error flag is dropped without being presented, and the read offset still advances.
- R11: Control bit 0 is the read/write enable. Control bit 31 is read-only and is 1 exactly when the read offset equals the write offset. All other control bits read as 0.
- R12: Writes to the read offset register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 base, 2 write offset, 3 read offset) |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit half access |
| reg_hi | input | 1 | For half access: 1 = bits 63:32, 0 = bits 31:0 |
| reg_wdata | input | 64 | Write data (a half access uses bits 31:0) |
| reg_rdata | output | 64 | Read data for the selected register and half |
| mem_req_valid | output | 1 | Command fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Physical address of the command |
| mem_rsp_valid | input | 1 | Fetch response strobe |
| mem_rsp_err | input | 1 | Fetch failed |
| mem_rsp_data | input | CMD_W | Fetched command bytes |
| cmd_valid | output | 1 | Command available to the consumer |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_data | output | CMD_W | Command bytes |

## Verification
The bench follows every fetch against its own model of the read offset. The sweep runs the ring all the way around its end. A design that does not wrap, or that wraps one slot late, gives a wrong fetch address just after the last slot. The bench also offers write offsets beyond the ring and writes both halves with stray bits set. If range checks or masking are missing, the readback values move. It holds the consumer back to see that the offset does not run ahead of acceptance, and it injects a fetch error to confirm that the failed slot is skipped and does not stall the ring. It also tries base writes while the unit is enabled, which must leave the offsets alone.

// File: rtl/cq_pkg.sv
// Shared definitions for the command queue ring controller.
// Assumes 32-byte commands and a ring sized in 4 KiB pages, at most 256 pages.
package cq_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_WOFF = 2'd2,
        SEL_ROFF = 2'd3
    } cq_sel_e;

    localparam int CMD_BYTES = 32;
    localparam int OFF_W     = 20;              // offsets span bits 19:0
    localparam int QL_W      = OFF_W + 1;       // ring length reaches 2^20
    localparam logic [63:0] OFF_MASK = 64'h0000_0000_000F_FFE0;

    // Merge a full or half write into a 64-bit register value.
    function automatic logic [63:0] cq_merge(input logic [63:0] old,
                                             input logic [63:0] wd,
                                             input logic wide,
                                             input logic hi);
        if (wide)
            return wd;
        else if (hi)
            return {wd[31:0], old[31:0]};
        else
            return {old[63:32], wd[31:0]};
    endfunction
endpackage

// File: rtl/cq_regs.sv
// Register block: control enable, base/size register and write offset.
// Makes the readback mux and the ring geometry (physical base, length).
// Assumes one access per cycle. The read offset is owned by the fetch engine.
module cq_regs
    import cq_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wide,
    input  logic               reg_hi,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [OFF_W-1:0]   rd_off,
    output logic               enable,
    output logic [63:0]        base,
    output logic [OFF_W-1:0]   woff,
    output logic [QL_W-1:0]    qlen,
    output logic [PA_W-1:0]    base_pa,
    output logic               clr
);
    logic [63:0] woff_cand;
    logic        woff_ok;
    logic        quiet;
    logic [63:0] sel_val;

    // Ring geometry decoded from the base register.
    assign qlen    = (QL_W'(base[7:0]) + QL_W'(1)) << 12;
    assign base_pa = {base[PA_W-1:12], 12'b0};

    // Accepted base write, which also empties the ring.
    assign clr = reg_wr && (reg_sel == SEL_BASE) && !enable;

    // Candidate write offset after merging and masking, plus its range check.
    always_comb begin
        woff_cand = cq_merge({{(64-OFF_W){1'b0}}, woff}, reg_wdata, reg_wide, reg_hi) & OFF_MASK;
        woff_ok   = woff_cand <= {{(64-QL_W){1'b0}}, qlen};
    end

    // State update for enable, base and write offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            base   <= '0;
            woff   <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_CTRL && (reg_wide || !reg_hi))
                enable <= reg_wdata[0];
            if (clr) begin
                base <= cq_merge(base, reg_wdata, reg_wide, reg_hi);
                woff <= '0;
            end
            if (reg_sel == SEL_WOFF && woff_ok)
                woff <= woff_cand[OFF_W-1:0];
        end
    end

    // Readback: pick the register, then the requested half.
    always_comb begin
        quiet = (rd_off == woff);
        unique case (reg_sel)
            SEL_CTRL: sel_val = {32'b0, quiet, 30'b0, enable};
            SEL_BASE: sel_val = base;
            SEL_WOFF: sel_val = {{(64-OFF_W){1'b0}}, woff};
            default:  sel_val = {{(64-OFF_W){1'b0}}, rd_off};
        endcase
        if (reg_wide)
            reg_rdata = sel_val;
        else if (reg_hi)
            reg_rdata = {32'b0, sel_val[63:32]};
        else
            reg_rdata = {32'b0, sel_val[31:0]};
    end
endmodule

// File: rtl/cq_fetch.sv
// Fetch engine: while the read offset trails the write offset, requests one
// command, waits for it, presents it and then advances with wrap.
// Assumes responses arrive in order, one per accepted request. A clear
// (accepted base write) drops any command in flight and drains a pending response.
module cq_fetch
    import cq_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int CMD_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [PA_W-1:0]    base_pa,
    input  logic [OFF_W-1:0]   woff,
    input  logic [QL_W-1:0]    qlen,
    output logic [OFF_W-1:0]   rd_off,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [CMD_W-1:0]   mem_rsp_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_data
);
    typedef enum logic [2:0] {F_IDLE, F_REQ, F_WAIT, F_OUT, F_DRAIN} fstate_e;

    fstate_e            st;
    logic [QL_W-1:0]    inc;
    logic [OFF_W-1:0]   nxt;
    logic               waiting;

    // Next read offset with wrap at the ring end.
    always_comb begin
        inc = QL_W'(rd_off) + QL_W'(CMD_BYTES);
        nxt = (inc == qlen) ? '0 : inc[OFF_W-1:0];
    end

    assign waiting       = (st == F_WAIT) || (st == F_DRAIN);
    assign mem_req_valid = (st == F_REQ);
    assign mem_req_addr  = base_pa + PA_W'(rd_off);
    assign cmd_valid     = (st == F_OUT);

    // Sequencing of a single command fetch and the read offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= F_IDLE;
            rd_off   <= '0;
            cmd_data <= '0;
        end else if (clr) begin
            rd_off <= '0;
            st     <= (waiting && !mem_rsp_valid) ? F_DRAIN : F_IDLE;
        end else begin
            unique case (st)
                F_IDLE:  if (rd_off != woff) st <= F_REQ;
                F_REQ:   if (mem_req_ready) st <= F_WAIT;
                F_WAIT:  if (mem_rsp_valid) begin
                             if (mem_rsp_err) begin
                                 rd_off <= nxt;
                                 st     <= F_IDLE;
                             end else begin
                                 cmd_data <= mem_rsp_data;
                                 st       <= F_OUT;
                             end
                         end
                F_OUT:   if (cmd_ready) begin
                             rd_off <= nxt;
                             st     <= F_IDLE;
                         end
                default: if (mem_rsp_valid) st <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cq_ring_ctrl.sv
// Top of the command queue ring controller: register block plus fetch engine.
// Assumes a single software access port and an in-order memory read channel.
module cq_ring_ctrl
    import cq_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int CMD_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wide,
    input  logic               reg_hi,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [CMD_W-1:0]   mem_rsp_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_data
);
    logic               en_q;
    logic [63:0]        base_q;
    logic [OFF_W-1:0]   woff_q;
    logic [OFF_W-1:0]   roff_q;
    logic [QL_W-1:0]    qlen_w;
    logic [PA_W-1:0]    base_pa_w;
    logic               clr_w;

    cq_regs #(.PA_W(PA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wide (reg_wide),
        .reg_hi   (reg_hi),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rd_off   (roff_q),
        .enable   (en_q),
        .base     (base_q),
        .woff     (woff_q),
        .qlen     (qlen_w),
        .base_pa  (base_pa_w),
        .clr      (clr_w)
    );

    cq_fetch #(.PA_W(PA_W), .CMD_W(CMD_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr_w),
        .base_pa      (base_pa_w),
        .woff         (woff_q),
        .qlen         (qlen_w),
        .rd_off       (roff_q),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err  (mem_rsp_err),
        .mem_rsp_data (mem_rsp_data),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_data     (cmd_data)
    );
endmodule

// File: rtl/cq_ring_checker.sv
// Protocol and state checks for cq_ring_ctrl, attached by bind.
// Assumes it sees the top-level state nets of the controller.
module cq_ring_checker
    import cq_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int CMD_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic               en,
    input  logic [63:0]        base,
    input  logic [OFF_W-1:0]   woff,
    input  logic [OFF_W-1:0]   roff,
    input  logic [QL_W-1:0]    qlen,
    input  logic               clr,
    input  logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic [PA_W-1:0]    mem_req_addr,
    input  logic               cmd_valid,
    input  logic               cmd_ready,
    input  logic [CMD_W-1:0]   cmd_data
);
    p_base_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_BASE && en) |=> $stable(base));

    p_clear_offsets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (roff == '0 && woff == '0));

    p_woff_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        QL_W'(woff) <= qlen);

    p_single_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, cmd_valid}));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !clr) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !clr) |=> (cmd_valid && $stable(cmd_data)));

    p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !clr) |=> (roff != $past(roff)));

    p_roff_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        QL_W'(roff) < qlen);
endmodule

bind cq_ring_ctrl cq_ring_checker #(.PA_W(PA_W), .CMD_W(CMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .en           (en_q),
    .base         (base_q),
    .woff         (woff_q),
    .roff         (roff_q),
    .qlen         (qlen_w),
    .clr          (clr_w),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_data     (cmd_data)
);

// File: tb/tb_cq_ring_ctrl.sv
// Self-checking bench: memory model, consumer model and a register sweep.
module tb_cq_ring_ctrl;
    localparam int PA_W  = 52;
    localparam int CMD_W = 256;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [1:0]         reg_sel = 2'd0;
    logic               reg_wide = 1'b1;
    logic               reg_hi = 1'b0;
    logic [63:0]        reg_wdata = '0;
    logic [63:0]        reg_rdata;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b1;
    logic [PA_W-1:0]    mem_req_addr;
    logic               mem_rsp_valid = 1'b0;
    logic               mem_rsp_err = 1'b0;
    logic [CMD_W-1:0]   mem_rsp_data = '0;
    logic               cmd_valid;
    logic               cmd_ready = 1'b1;
    logic [CMD_W-1:0]   cmd_data;

    cq_ring_ctrl #(.PA_W(PA_W), .CMD_W(CMD_W)) dut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int col_chk = 0, col_bad = 0, col_n = 0;
    logic [63:0] exp_base = '0;
    int          exp_qlen = 4096;
    logic        exp_en = 1'b0;
    logic [PA_W-1:0] err_addr = '1;

    // Memory responder and command consumer model with its own read offset.
    logic            pend = 1'b0;
    logic [PA_W-1:0] paddr = '0;
    int              exp_rd = 0;
    always begin
        @(negedge clk);
        #2;
        if (reg_wr && reg_sel == 2'd1 && !exp_en) exp_rd = 0;
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {4{{(64-PA_W){1'b0}}, paddr}};
            mem_rsp_err   = (paddr == err_addr);
            pend = 1'b0;
            if (mem_rsp_err) exp_rd = (exp_rd + 32 == exp_qlen) ? 0 : exp_rd + 32;
        end
        if (mem_req_valid && mem_req_ready) begin
            pend  = 1'b1;
            paddr = mem_req_addr;
        end
        if (cmd_valid && cmd_ready) begin
            logic [PA_W-1:0] ea;
            ea = {exp_base[PA_W-1:12], 12'b0} + PA_W'(exp_rd);
            col_chk++;
            col_n++;
            if (cmd_data !== {4{{(64-PA_W){1'b0}}, ea}}) begin
                col_bad++;
                $display("FAIL R7/R9 command act=%h exp=%h", cmd_data[PA_W-1:0], ea);
            end
            exp_rd = (exp_rd + 32 == exp_qlen) ? 0 : exp_rd + 32;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rreg(input logic [1:0] sel, input logic wide, input logic hi, output logic [63:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = sel; reg_wide = wide; reg_hi = hi;
        #1 v = reg_rdata;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic wide, input logic hi, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wide = wide; reg_hi = hi; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic wait_quiet(input string tag);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 4000; i++) begin
            rreg(2'd0, 1'b1, 1'b0, v);
            if (v[31]) break;
        end
        chk(tag, {63'b0, v[31]}, 64'd1);
    endtask

    task automatic fin();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + col_chk, n_bad + col_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            fin();
        end
    end

    initial begin
        logic [63:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rreg(2'd0, 1'b1, 1'b0, v); chk("R1 ctrl", v, 64'h8000_0000);
        rreg(2'd1, 1'b1, 1'b0, v); chk("R1 base", v, 64'h0);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R1 woff", v, 64'h0);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R1 roff", v, 64'h0);
        chk("R1 idle ports", {62'b0, mem_req_valid, cmd_valid}, 64'h0);

        // R2: full and half writes and reads of the base register
        wreg(2'd1, 1'b1, 1'b0, 64'h1111_2222_3333_4000);
        wreg(2'd1, 1'b0, 1'b1, 64'hFFFF_FFFF_AAAA_5555);
        rreg(2'd1, 1'b1, 1'b0, v); chk("R2 wide read", v, 64'hAAAA_5555_3333_4000);
        rreg(2'd1, 1'b0, 1'b0, v); chk("R2 low read", v, 64'h3333_4000);
        rreg(2'd1, 1'b0, 1'b1, v); chk("R2 high read", v, 64'hAAAA_5555);
        exp_base = 64'hAAAA_5555_1234_5000; exp_qlen = 4096;
        wreg(2'd1, 1'b0, 1'b0, 64'h0000_0000_1234_5000);
        rreg(2'd1, 1'b1, 1'b0, v); chk("R2 low write", v, exp_base);

        // R3 + R7: masked write offset, three fetches
        c0 = col_n;
        wreg(2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_007F);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R3 woff mask", v, 64'h60);
        wait_quiet("R11 quiet after fetch");
        chk("R7 command count", 64'(col_n - c0), 64'd3);
        wreg(2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R3 high half dropped", v, 64'h60);
        rreg(2'd3, 1'b0, 1'b1, v); chk("R3 roff high zero", v, 64'h0);

        // R6: out-of-range write offset discarded
        wreg(2'd2, 1'b1, 1'b0, 64'h2000);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R6 woff kept", v, 64'h60);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R6 roff kept", v, 64'h60);

        // R8: held command does not advance the read offset
        cmd_ready = 1'b0;
        wreg(2'd2, 1'b1, 1'b0, 64'h80);
        repeat (20) @(negedge clk);
        chk("R8 cmd held", {63'b0, cmd_valid}, 64'd1);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R8 roff not advanced", v, 64'h60);
        rreg(2'd0, 1'b1, 1'b0, v); chk("R11 busy ctrl", v, 64'h0);
        cmd_ready = 1'b1;
        wait_quiet("R8 drain");
        rreg(2'd3, 1'b1, 1'b0, v); chk("R8 roff advanced", v, 64'h80);

        // R9: run to the end of the ring and wrap
        wreg(2'd2, 1'b1, 1'b0, 64'hFE0);
        wait_quiet("R9 near end");
        c0 = col_n;
        wreg(2'd2, 1'b1, 1'b0, 64'h40);
        wait_quiet("R9 wrapped");
        rreg(2'd3, 1'b1, 1'b0, v); chk("R9 roff after wrap", v, 64'h40);
        chk("R9 wrap count", 64'(col_n - c0), 64'd3);

        // R10: failed fetch skipped
        err_addr = {exp_base[PA_W-1:12], 12'b0} + PA_W'(32'h60);
        c0 = col_n;
        wreg(2'd2, 1'b1, 1'b0, 64'hA0);
        wait_quiet("R10 drain");
        chk("R10 presented count", 64'(col_n - c0), 64'd2);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R10 roff advanced", v, 64'hA0);
        err_addr = '1;

        // R11, R4, R12: enable, locked base, read-only read offset
        wreg(2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF);
        exp_en = 1'b1;
        rreg(2'd0, 1'b1, 1'b0, v); chk("R11 ctrl enabled", v, 64'h8000_0001);
        wreg(2'd1, 1'b1, 1'b0, 64'h0000_0000_0BAD_0003);
        rreg(2'd1, 1'b1, 1'b0, v); chk("R4 base locked", v, exp_base);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R4 roff kept", v, 64'hA0);
        wreg(2'd3, 1'b1, 1'b0, 64'h20);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R12 roff read-only", v, 64'hA0);
        wreg(2'd0, 1'b0, 1'b0, 64'h0);
        exp_en = 1'b0;
        rreg(2'd0, 1'b1, 1'b0, v); chk("R11 ctrl disabled", v, 64'h8000_0000);

        // R5 + R6 + R7: new two-page ring, long sweep
        exp_base = 64'h0000_0000_0ABC_0001; exp_qlen = 8192;
        wreg(2'd1, 1'b1, 1'b0, exp_base);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R5 roff cleared", v, 64'h0);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R5 woff cleared", v, 64'h0);
        wreg(2'd2, 1'b1, 1'b0, 64'h2020);
        rreg(2'd2, 1'b1, 1'b0, v); chk("R6 beyond two pages", v, 64'h0);
        c0 = col_n;
        wreg(2'd2, 1'b1, 1'b0, 64'h1800);
        wait_quiet("R7 sweep drain");
        chk("R7 sweep count", 64'(col_n - c0), 64'd192);
        rreg(2'd3, 1'b1, 1'b0, v); chk("R7 sweep roff", v, 64'h1800);
        fin();
    end
endmodule